// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Override

This block is an eight-pin general-purpose I/O port. Software controls it through a small register bus with an address, a write strobe, a read strobe and byte-wide data. Three registers are visible. The direction register sets, per pin, whether the pad driver is enabled. The output latch holds the value to drive. The port address returns the live pin level on a read and loads the output latch on a write.

Each pin can also be handed to an on-chip peripheral. While a pin's peripheral select is high, the peripheral's data bit is what goes to the pad, and the peripheral's own enable decides whether the driver is on. This can force the pin to an output or to an input, whatever the direction bit says. The override acts only on the pad drive. The stored direction register is never altered, so software can read-modify-write it safely while a peripheral owns some pins.

Pin levels pass through a two-stage synchronizer. The synchronized levels feed the port read path and also a per-pin data-in bus toward the peripherals. That bus is always live, whatever the override state.

Top module: `gpio_override_port`

## Requirements
- R1: After synchronous reset, the direction register reads 0xFF, the output latch reads 0x00 and no pad output enable is active.
- R2: A write to address 1 (latch) or address 0 (port) loads the output latch. A read of address 1 returns the stored latch value, not the pin level.
- R3: Direction bit 1 means input: that pad's output enable is 0. Direction bit 0 means output: the enable is 1 and the pad drives the latch bit. Writing 0xCF to address 2 (direction) makes pins 5:4 outputs and all other pins inputs.
- R4: A read of address 0 returns the synchronized pin levels. A pin change reaches the synchronized value on the second rising clock edge after it, not on the first.
- R5: The peripheral data-in output always equals the synchronized pin levels, whatever the override settings.
- R6: While a pin's peripheral select is 1, its pad value is the peripheral data bit and its pad enable is the peripheral enable bit. While the select is 0, the peripheral enable bit of that pin has no effect.
- R7: Peripheral overrides never change the direction register. A read of address 2 returns exactly the value software last wrote.
- R8: A read of address 3 returns 0x00. A write to address 3 changes neither the latch nor the direction register.
- R9: Read data appears on the cycle after the read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin pad driver enable |
| pad_out | output | 8 | Per-pin pad output value |
| per_sel | input | 8 | Per-pin peripheral select |
| per_oe | input | 8 | Per-pin peripheral output enable |
| per_dout | input | 8 | Per-pin peripheral output data |
| per_din | output | 8 | Synchronized pin levels toward peripherals |

## Verification
A corrupted direction or latch register shows on pad_oe and pad_out at once, because they are combinational from the stored state. It also shows on the next register read. If an override were written into the direction register, it would surface on the first direction read after the select changes. A synchronizer with the wrong depth shows as per_din and port reads changing one edge early or late after a pin change. The bench probes exactly those two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W     = 8;
    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_PORT  = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_LATCH = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIR   = 2'd2;

    typedef enum logic [1:0] {
        SEL_PORT  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_PORT:  s = SEL_PORT;
            ADDR_LATCH: s = SEL_LATCH;
            ADDR_DIR:   s = SEL_DIR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic loads_latch(input reg_sel_e s);
        return (s == SEL_PORT) || (s == SEL_LATCH);
    endfunction

endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);

    localparam logic [WIDTH-1:0] DIR_RESET   = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] LATCH_RESET = '0;

    logic latch_we;
    logic dir_we;

    always_comb begin
        latch_we = wr && loads_latch(sel);
        dir_we   = wr && (sel == SEL_DIR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= LATCH_RESET;
        end else if (latch_we) begin
            latch_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_RESET;
        end else if (dir_we) begin
            dir_q <= wdata;
        end
    end

    // R1
    dir_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dir_q == DIR_RESET && latch_q == LATCH_RESET));

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && loads_latch(sel)) |=> (latch_q == $past(wdata)));

    // R7
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == SEL_DIR) |=> $stable(dir_q));

    // R8
    none_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |=> ($stable(dir_q) && $stable(latch_q)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
#(
    parameter int WIDTH  = PORT_W,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= pin_in;
        end
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[k] <= '0;
                end else begin
                    stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[LAST];

    // R4
    sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (stage_q[0] == $past(pin_in)));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] per_sel,
    input  logic [WIDTH-1:0] per_oe,
    input  logic [WIDTH-1:0] per_dout,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic port_oe;
            logic port_val;

            always_comb begin
                port_oe  = ~dir_q[i];
                port_val = latch_q[i];
                if (per_sel[i]) begin
                    pad_oe[i]  = per_oe[i];
                    pad_out[i] = per_dout[i];
                end else begin
                    pad_oe[i]  = port_oe;
                    pad_out[i] = port_val;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] rd_next;

    always_comb begin
        unique case (sel)
            SEL_PORT:  rd_next = pin_sync;
            SEL_LATCH: rd_next = latch_q;
            SEL_DIR:   rd_next = dir_q;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_next;
        end
    end

    // R8
    undef_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_NONE) |=> (rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    // R2
    latch_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_LATCH) |=> (rdata == $past(latch_q)));

endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = PORT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_out,
    input  logic [WIDTH-1:0]      per_sel,
    input  logic [WIDTH-1:0]      per_oe,
    input  logic [WIDTH-1:0]      per_dout,
    output logic [WIDTH-1:0]      per_din
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    assign sel = decode_addr(bus_addr);

    gpio_reg_file #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .dir_q    (dir_q),
        .latch_q  (latch_q),
        .per_sel  (per_sel),
        .per_oe   (per_oe),
        .per_dout (per_dout),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (bus_rd),
        .sel      (sel),
        .pin_sync (pin_sync),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .rdata    (bus_rdata)
    );

    assign per_din = pin_sync;

    // R6
    drive_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(per_sel) && $stable(per_oe) && $stable(dir_q)) |-> $stable(pad_oe));

    // R3
    reset_pads_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && per_sel == '0) |-> (pad_oe == '0));

    // R5
    din_port_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_PORT) |=> (bus_rdata == $past(per_din)));

endmodule

// File: tb/gpio_override_port_test.sv
module gpio_override_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] per_sel = '0;
    logic [7:0] per_oe = '0;
    logic [7:0] per_dout = '0;
    logic [7:0] per_din;
    logic [7:0] ext_level = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    // Pads: driven pins loop back, others follow the external level.
    assign pin_in = (pad_oe & pad_out) | (~pad_oe & ext_level);

    gpio_override_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .per_sel(per_sel), .per_oe(per_oe),
        .per_dout(per_dout), .per_din(per_din)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        bus_read(2'd2, v); check("R1 dir reset", v, 8'hFF);
        bus_read(2'd1, v); check("R1 latch reset", v, 8'h00);
    endtask

    task automatic t_latch_rw();
        logic [7:0] v;
        bus_write(2'd1, 8'hA5);
        bus_read(2'd1, v); check("R2 latch via addr1", v, 8'hA5);
        bus_write(2'd0, 8'h3C);
        bus_read(2'd1, v); check("R2 latch via port addr", v, 8'h3C);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        bus_write(2'd2, 8'hCF);
        check("R3 pad_oe for 0xCF", pad_oe, 8'h30);
        check("R3 pad_out on outputs", pad_out & 8'h30, 8'h30);
        bus_read(2'd2, v); check("R3 dir readback", v, 8'hCF);
    endtask

    task automatic t_port_read();
        logic [7:0] v;
        @(negedge clk);
        ext_level = 8'h0F;
        @(negedge clk);
        check("R4 one edge: not yet", per_din, 8'h30);
        @(negedge clk);
        check("R4 two edges: updated", per_din, 8'h3F);
        bus_read(2'd0, v); check("R4 port read pin level", v, 8'h3F);
        bus_read(2'd1, v); check("R2 latch read not pins", v, 8'h3C);
    endtask

    task automatic t_override();
        logic [7:0] v;
        @(negedge clk);
        per_sel = 8'h91; per_oe = 8'h03; per_dout = 8'h01;
        #1;
        check("R6 override enables", pad_oe, 8'h21);
        check("R6 override value pin0", {7'd0, pad_out[0]}, 8'h01);
        repeat (3) @(negedge clk);
        check("R5 per_din under override", per_din, 8'h2F);
        bus_read(2'd2, v); check("R7 dir unchanged by override", v, 8'hCF);
        bus_write(2'd2, 8'hC3);
        bus_read(2'd2, v); check("R7 dir software value", v, 8'hC3);
        @(negedge clk);
        per_sel = '0; per_oe = '0; per_dout = '0;
        #1;
        check("R6 release restores dir drive", pad_oe, 8'h3C);
        bus_write(2'd2, 8'hCF);
    endtask

    task automatic t_undefined();
        logic [7:0] v;
        bus_write(2'd3, 8'h55);
        bus_read(2'd1, v); check("R8 latch after addr3 write", v, 8'h3C);
        bus_read(2'd2, v); check("R8 dir after addr3 write", v, 8'hCF);
        bus_read(2'd3, v); check("R8 addr3 read zero", v, 8'h00);
    endtask

    task automatic t_read_hold();
        logic [7:0] v;
        bus_read(2'd1, v); check("R9 read latch", v, 8'h3C);
        bus_write(2'd1, 8'h77);
        repeat (2) @(negedge clk);
        check("R9 rdata held", bus_rdata, 8'h3C);
        bus_read(2'd1, v); check("R9 new read", v, 8'h77);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch_rw();
        t_direction();
        t_port_read();
        t_override();
        t_undefined();
        t_read_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule